// File: doc/BRIEF.md
# Router Power-Gating Controller

This block is the per-router controller that decides when the power domain of one mesh router is switched off and when it is switched back on. It watches a router idle indication. After a fixed run of consecutive idle cycles it asserts the sleep control. While the router is unpowered or still waking, it steers traffic into the bypass path. Injection, forwarding and ejection therefore carry on without the router.

Wake-up is column-wide rather than per packet. Each controller watches the occupancy of its local bypass buffer. When the occupancy stays at or above a programmable high-water mark for a set number of cycles, the controller raises a column wake request. The column's requests are combined outside the block and fed back to every controller in that column as a column wake input.

A gated router stays off for at least a break-even interval. A wake request that arrives during that interval is remembered and served when the interval ends. After the sleep control is released, the router is declared ready after a fixed wake latency, and only once power-good is also present.

Top module: `rpg_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, `sleep_o`=0, `ready_o`=1, `bypass_sel_o`=0 and `col_wake_req_o`=0.
- R2: With `router_idle_i`=1 and no wake request, `sleep_o` rises at the clock edge that samples the IDLE_CYC-th (default 4) consecutive idle cycle. `ready_o` falls and `bypass_sel_o` rises on that same edge, and `sleep_o` and `ready_o` are never both 1.
- R3: A sample with `router_idle_i`=0, or with a wake request present, during the idle wait returns the controller to the powered state and restarts the idle count. A full IDLE_CYC fresh idle samples are then needed to gate.
- R4: Once `sleep_o` rises, it stays 1 for at least HOLD_CYC (default 10) cycles. With a wake request held high from the start, it falls exactly at the HOLD_CYC-th edge after it rose.
- R5: A wake request pulse of a single cycle during the break-even hold is latched. `sleep_o` then falls at the HOLD_CYC-th edge after it rose.
- R6: While gated with no wake request, the controller stays gated indefinitely, whatever the value of `router_idle_i`.
- R7: With `pwr_good_i`=1, `ready_o` rises exactly WAKE_CYC (default 8) edges after `sleep_o` falls. While `pwr_good_i`=0, `ready_o` stays 0, and it rises at the first edge that samples `pwr_good_i`=1 once the latency has elapsed.
- R8: `bypass_sel_o` is always the inverse of `ready_o`.
- R9: `col_wake_req_o` rises at the edge that samples the HW_PERSIST-th (default 3) consecutive cycle with `bypass_occ_i` >= `hw_thresh_i` (unsigned). It falls at the first edge that samples `bypass_occ_i` < `hw_thresh_i`, and shorter runs never raise it.
- R10: The controller's own `col_wake_req_o` acts as a wake request for its router, exactly like `col_wake_i`, one cycle after the request rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| router_idle_i | input | 1 | 1 when the router saw no flit activity this cycle |
| col_wake_i | input | 1 | Combined wake request of the router's column |
| pwr_good_i | input | 1 | Power-good acknowledgment from the power switches |
| bypass_occ_i | input | OCC_W | Current occupancy of the local bypass buffer |
| hw_thresh_i | input | OCC_W | Programmable high-water threshold |
| sleep_o | output | 1 | 1 switches the router's power domain off |
| ready_o | output | 1 | 1 when the router may accept flits |
| bypass_sel_o | output | 1 | 1 steers traffic into the bypass path |
| col_wake_req_o | output | 1 | This node's contribution to the column wake request |

## Verification
The bench builds the block with its default parameters: an idle wait of 4, a break-even hold of 10, a wake latency of 8, a persistence of 3 and a 4-bit occupancy. These small values bring every counter boundary within reach in a few dozen cycles. They include the edge just before and the edge at which the hold and the latency expire, a long stay while gated, and an occupancy run one cycle short of the persistence. The threshold is driven through several values, so equality and strict excess of the high-water mark are both exercised.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef enum logic [1:0] {
    PG_ON    = 2'd0,
    PG_WAIT  = 2'd1,
    PG_OFF   = 2'd2,
    PG_WAKE  = 2'd3
  } pg_state_t;
endpackage

// File: rtl/rpg_fsm.sv
module rpg_fsm
  import rpg_pkg::*;
#(
  parameter int IDLE_CYC = 4,
  parameter int HOLD_CYC = 10,
  parameter int WAKE_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic idle_i,
  input  logic wake_i,
  input  logic pgood_i,
  output logic sleep_o,
  output logic ready_o,
  output logic bypass_o
);
  localparam int MAX_A = (IDLE_CYC > HOLD_CYC) ? IDLE_CYC : HOLD_CYC;
  localparam int MAX_C = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);

  pg_state_t st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic pend_q, pend_n;
  logic up_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    pend_n = pend_q;
    unique case (st_q)
      PG_ON: begin
        cnt_n  = '0;
        pend_n = 1'b0;
        if (idle_i && !wake_i) begin
          if (IDLE_LAST == '0) begin
            st_n = PG_OFF;
          end else begin
            st_n  = PG_WAIT;
            cnt_n = CNT_W'(1);
          end
        end
      end
      PG_WAIT: begin
        if (!idle_i || wake_i) begin
          st_n  = PG_ON;
          cnt_n = '0;
        end else if (cnt_q == IDLE_LAST) begin
          st_n  = PG_OFF;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PG_OFF: begin
        pend_n = pend_q | wake_i;
        if (cnt_q == HOLD_LAST && (pend_q || wake_i)) begin
          st_n   = PG_WAKE;
          cnt_n  = '0;
          pend_n = 1'b0;
        end else if (cnt_q != HOLD_LAST) begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PG_WAKE: begin
        if (cnt_q == WAKE_LAST && pgood_i) begin
          st_n  = PG_ON;
          cnt_n = '0;
        end else if (cnt_q != WAKE_LAST) begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: st_n = PG_ON;
    endcase
  end

  assign up_n = (st_n == PG_ON) || (st_n == PG_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= PG_ON;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      sleep_o  <= 1'b0;
      ready_o  <= 1'b1;
      bypass_o <= 1'b0;
    end else begin
      st_q     <= st_n;
      cnt_q    <= cnt_n;
      pend_q   <= pend_n;
      sleep_o  <= (st_n == PG_OFF);
      ready_o  <= up_n;
      bypass_o <= !up_n;
    end
  end

  // Checker: length of the current gated stretch, saturating.
  localparam int OFFL_W = $clog2(HOLD_CYC + 2);
  localparam logic [OFFL_W-1:0] OFFL_MAX = OFFL_W'(HOLD_CYC + 1);
  logic [OFFL_W-1:0] off_len;
  always_ff @(posedge clk) begin
    if (rst) off_len <= '0;
    else if (!sleep_o) off_len <= '0;
    else if (off_len != OFFL_MAX) off_len <= off_len + 1'b1;
  end

  assert_min_off_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_o) |-> (off_len >= OFFL_W'(HOLD_CYC)));
  assert_gate_on_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_o) |-> $past(idle_i));
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(sleep_o && ready_o));
  assert_ready_pgood_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(pgood_i));
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    bypass_o != ready_o);
endmodule

// File: rtl/rpg_hwm.sv
module rpg_hwm #(
  parameter int OCC_W      = 4,
  parameter int HW_PERSIST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] thr_i,
  output logic             req_o
);
  localparam int PW = $clog2(HW_PERSIST + 1);
  localparam logic [PW-1:0] P_LAST = PW'(HW_PERSIST - 1);

  logic [PW-1:0] run_q;
  logic          above;

  assign above = (occ_i >= thr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      req_o <= 1'b0;
    end else if (!above) begin
      run_q <= '0;
      req_o <= 1'b0;
    end else if (run_q == P_LAST) begin
      req_o <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assert_req_above_R9: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(above));
  assert_req_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(run_q == P_LAST));
endmodule

// File: rtl/rpg_ctrl.sv
module rpg_ctrl #(
  parameter int IDLE_CYC   = 4,
  parameter int HOLD_CYC   = 10,
  parameter int WAKE_CYC   = 8,
  parameter int OCC_W      = 4,
  parameter int HW_PERSIST = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             router_idle_i,
  input  logic             col_wake_i,
  input  logic             pwr_good_i,
  input  logic [OCC_W-1:0] bypass_occ_i,
  input  logic [OCC_W-1:0] hw_thresh_i,
  output logic             sleep_o,
  output logic             ready_o,
  output logic             bypass_sel_o,
  output logic             col_wake_req_o
);
  logic wake_any;

  // R10: the node's own request joins the column request.
  assign wake_any = col_wake_i | col_wake_req_o;

  rpg_hwm #(.OCC_W(OCC_W), .HW_PERSIST(HW_PERSIST)) u_hwm (
    .clk   (clk),
    .rst   (rst),
    .occ_i (bypass_occ_i),
    .thr_i (hw_thresh_i),
    .req_o (col_wake_req_o)
  );

  rpg_fsm #(.IDLE_CYC(IDLE_CYC), .HOLD_CYC(HOLD_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .idle_i   (router_idle_i),
    .wake_i   (wake_any),
    .pgood_i  (pwr_good_i),
    .sleep_o  (sleep_o),
    .ready_o  (ready_o),
    .bypass_o (bypass_sel_o)
  );

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sleep_o && ready_o && !col_wake_req_o));
endmodule

// File: tb/rpg_ctrl_tb_top.sv
`timescale 1ns/1ps
module rpg_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle = 1'b0, cwake = 1'b0, pgood = 1'b1;
  logic [3:0] occ = '0, thr = 4'd15;
  logic sleep, ready, byp, creq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rpg_ctrl dut_i (
    .clk(clk), .rst(rst), .router_idle_i(idle), .col_wake_i(cwake),
    .pwr_good_i(pgood), .bypass_occ_i(occ), .hw_thresh_i(thr),
    .sleep_o(sleep), .ready_o(ready), .bypass_sel_o(byp),
    .col_wake_req_o(creq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic go_off();
    idle = 1'b1;
    tick(4);
    idle = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(2);
    chk("R1", "sleep", sleep, 1'b0);
    chk("R1", "ready", ready, 1'b1);
    chk("R1", "bypass", byp, 1'b0);
    chk("R1", "creq", creq, 1'b0);
    rst = 1'b0; tick(1);
    chk("R1", "ready after release", ready, 1'b1);
  endtask

  task automatic t_gate();
    idle = 1'b1; tick(3);
    chk("R2", "sleep after 3 idle", sleep, 1'b0);
    tick(1);
    chk("R2", "sleep after 4 idle", sleep, 1'b1);
    chk("R2", "ready gated", ready, 1'b0);
    chk("R8", "bypass gated", byp, 1'b1);
    idle = 1'b0;
  endtask

  task automatic t_hold_and_wake();
    // entered gated state at the last edge
    cwake = 1'b1; tick(9);
    chk("R4", "sleep at edge 9", sleep, 1'b1);
    tick(1);
    chk("R4", "sleep at edge 10", sleep, 1'b0);
    cwake = 1'b0;
    tick(7);
    chk("R7", "ready 7 after wake", ready, 1'b0);
    chk("R8", "bypass while waking", byp, 1'b1);
    tick(1);
    chk("R7", "ready 8 after wake", ready, 1'b1);
    chk("R8", "bypass released", byp, 1'b0);
  endtask

  task automatic t_abort();
    idle = 1'b1; tick(3);
    idle = 1'b0; tick(1);
    idle = 1'b1; tick(3);
    chk("R3", "restart after busy", sleep, 1'b0);
    idle = 1'b0; tick(1);
    idle = 1'b1; tick(2);
    cwake = 1'b1; tick(1);
    cwake = 1'b0; tick(3);
    chk("R3", "restart after wake", sleep, 1'b0);
    tick(1);
    chk("R3", "gate after fresh 4", sleep, 1'b1);
    idle = 1'b0;
    cwake = 1'b1; tick(10); cwake = 1'b0; tick(8);
    chk("R7", "back on", ready, 1'b1);
  endtask

  task automatic t_latch();
    go_off();
    tick(2);
    cwake = 1'b1; tick(1); cwake = 1'b0;
    tick(6);
    chk("R5", "sleep at edge 9", sleep, 1'b1);
    tick(1);
    chk("R5", "latched wake served", sleep, 1'b0);
    tick(8);
    chk("R7", "ready after latched wake", ready, 1'b1);
  endtask

  task automatic t_stay_and_pgood();
    go_off();
    idle = 1'b1; tick(20); idle = 1'b0; tick(20);
    chk("R6", "stays gated", sleep, 1'b1);
    chk("R6", "stays not ready", ready, 1'b0);
    pgood = 1'b0;
    cwake = 1'b1; tick(1); cwake = 1'b0;
    chk("R6", "wake after long stay", sleep, 1'b0);
    tick(12);
    chk("R7", "held without pgood", ready, 1'b0);
    pgood = 1'b1; tick(1);
    chk("R7", "ready on pgood", ready, 1'b1);
  endtask

  task automatic t_hwm();
    thr = 4'd6; occ = 4'd5; tick(5);
    chk("R9", "below thresh", creq, 1'b0);
    occ = 4'd6; tick(2);
    chk("R9", "run of 2", creq, 1'b0);
    occ = 4'd0; tick(1);
    occ = 4'd7; tick(2);
    chk("R9", "restart run of 2", creq, 1'b0);
    tick(1);
    chk("R9", "run of 3", creq, 1'b1);
    occ = 4'd2; tick(1);
    chk("R9", "drop below", creq, 1'b0);
  endtask

  task automatic t_self_wake();
    go_off();
    tick(10);
    chk("R6", "gated before self request", sleep, 1'b1);
    occ = 4'd9; tick(3);
    chk("R10", "req raised", creq, 1'b1);
    chk("R10", "still gated that edge", sleep, 1'b1);
    tick(1);
    chk("R10", "self request wakes", sleep, 1'b0);
    occ = 4'd0; tick(8);
    chk("R10", "ready after self wake", ready, 1'b1);
  endtask

  initial begin
    #1;
    t_reset();
    t_gate();
    t_hold_and_wake();
    t_abort();
    t_latch();
    t_stay_and_pgood();
    t_hwm();
    t_self_wake();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule